// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two expiry stages. A down-counter is decremented by one on every pulse of a tick-enable input. That input stands for a slow time base of roughly 0.6 s per tick. When the counter expires for the first time, the block sets a warning flag, fires a one-cycle interrupt and restarts the countdown from a programmed initial value. If the counter expires again while the warning flag is still set, the block raises a sticky system reset request. A no-reboot control bit can block that request.

Software reaches the block through a 16-bit register port with a write strobe and two byte-lane enables. Reads are combinational on the address.

- Writing anything to the reload register restarts the countdown.
- Writing a one to the warning flag clears it, so the timer must then expire twice more before a reset.
- A halt bit freezes counting.
- The reload, status, control and initial-value registers sit at fixed offsets.

The controller has three named states:

- `S_HALT`: the halt bit is set and the counter is frozen.
- `S_RUN`: the counter runs.
- `S_FIRED`: the reset request has been issued. This state is left only through `rst_n`.

The transitions are:

- `S_HALT`→`S_RUN` when the halt bit is 0.
- `S_RUN`→`S_HALT` when the halt bit is 1.
- `S_RUN`→`S_FIRED` on a second expiry with no-reboot clear.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the following hold. Control at 0x08 reads 0x0800, meaning halted. The initial value at 0x12 reads 0x0004 and the count at 0x00 reads 4. Offsets 0x04 and 0x06 read 0. `rst_req` and `irq_first` are 0.
- R2: While running, each cycle with `tick_en` high lowers the count (0x00, bits 9:0) by one. While halted the count holds.
- R3: Any write to 0x00 with at least one lane enabled loads the count from the initial value. If a tick falls in the same cycle, the reload wins and no expiry happens.
- R4: At 0x12, bits 9:0 are the initial value and bits 15:10 are plain storage. A write that would leave bits 9:0 below 4 keeps the old bits 9:0 but still stores bits 15:10.
- R5: A tick at count 0 with the warning flag (0x04 bit 3) clear has three effects. It sets the flag, reloads the count from the initial value, and pulses `irq_first` high for exactly one cycle.
- R6: A tick at count 0 with the flag set does the following:
  - It sets bit 1 of 0x06.
  - If no-reboot (0x08 bit 0) is 0, it also sets bit 2 of 0x06 and raises `rst_req`, and the count then stays frozen.
- R7: With no-reboot set, a second expiry sets only 0x06 bit 1. The count reloads and counting goes on, and `rst_req` stays 0.
- R8: Writing 1 to 0x04 bit 3, or to 0x06 bits 1 and 2, clears those bits. Writing 0 leaves them unchanged. An expiry that sets a bit wins over a clear in the same cycle. After the flag is cleared, the next expiry is again a first expiry.
- R9: Writing 1 to 0x08 bit 8 inverts the stored bit, and writing 0 leaves it unchanged. The bit has no effect on counting.
- R10: `rst_req` stays high through later writes and ticks until `rst_n` is asserted.
- R11: 0x08 bit 11 set to 1 halts the counter and set to 0 lets it run. Halting keeps the warning flag.
- R12: `wr_be[0]` enables data bits 7:0 and `wr_be[1]` enables bits 15:8. A disabled lane keeps its stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle time-base tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| wr_be | input | 2 | Write byte-lane enables |
| rdata | output | 16 | Read data for `addr` |
| irq_first | output | 1 | One-cycle pulse on first expiry |
| rst_req | output | 1 | Sticky system reset request |

## Verification
Two things can fall on the same clock edge. A software reload write can land on the edge where a tick finds the count at zero. A write-one-clear of the warning flag can land on the edge of an expiry. The bench drives `tick_en` and the write strobe together in a single cycle to provoke each case. For the reload case it expects the reloaded count, no interrupt pulse and an unchanged flag. For the clear-versus-expiry case it expects the flag to end up set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 16;

    localparam logic [4:0] OFF_RELOAD = 5'h00;
    localparam logic [4:0] OFF_STS1   = 5'h04;
    localparam logic [4:0] OFF_STS2   = 5'h06;
    localparam logic [4:0] OFF_CTL1   = 5'h08;
    localparam logic [4:0] OFF_INIT   = 5'h12;

    localparam int BIT_WARN    = 3;
    localparam int BIT_SECOND  = 1;
    localparam int BIT_BOOT    = 2;
    localparam int BIT_NOREBT  = 0;
    localparam int BIT_DUMMY   = 8;
    localparam int BIT_HALT    = 11;

    typedef enum logic [1:0] {
        S_HALT  = 2'd0,
        S_RUN   = 2'd1,
        S_FIRED = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(INIT_RST);

    assign expire = run && tick && !reload && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= RST_VAL;
        end else if (reload) begin
            count <= init_val;
        end else if (run && tick) begin
            count <= (count == '0) ? init_val : count - 1'b1;
        end
    end

    // R2: frozen when not running and no reload
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(count));
    // R2: one step per tick
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !reload && count != '0) |=> count == $past(count) - 1'b1);
    // R3: reload loads initial value
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == $past(init_val));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic noreboot,
    input  logic flag,
    input  logic expire,
    output logic run,
    output logic set_first,
    output logic set_second,
    output logic set_boot,
    output logic irq,
    output logic rst_req
);
    wd_state_e state_q, state_d;
    logic      fire;

    assign set_first  = expire && !flag;
    assign set_second = expire && flag;
    assign fire       = set_second && !noreboot;
    assign set_boot   = fire;
    assign run        = (state_q == S_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HALT:  if (!halt) state_d = S_RUN;
            S_RUN: begin
                if (fire)      state_d = S_FIRED;
                else if (halt) state_d = S_HALT;
            end
            S_FIRED: state_d = S_FIRED;
            default: state_d = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq     <= set_first;
            rst_req <= rst_req | fire;
        end
    end

    // R5: interrupt is a single-cycle pulse
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R10: reset request is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    // R7: no-reboot blocks a new request
    a_r7_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (noreboot && !rst_req) |=> !rst_req);
    // R6: a request means the counter is stopped
    a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !run);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        wr_be,
    input  logic [CNT_W-1:0]  count,
    input  logic              set_first,
    input  logic              set_second,
    input  logic              set_boot,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  init_val,
    output logic              halt,
    output logic              noreboot,
    output logic              flag,
    output logic              reload
);
    localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(INIT_MIN);

    logic [DATA_W-1:0] init_q, init_m, ctl_view;
    logic              dummy, second_q, boot_q;
    logic              wr_init, wr_ctl, wr_s1, wr_s2;

    function automatic logic [DATA_W-1:0] lanes(input logic [DATA_W-1:0] old,
                                                 input logic [DATA_W-1:0] nw,
                                                 input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    assign wr_init = wr_en && addr == OFF_INIT;
    assign wr_ctl  = wr_en && addr == OFF_CTL1;
    assign wr_s1   = wr_en && addr == OFF_STS1 && wr_be[0];
    assign wr_s2   = wr_en && addr == OFF_STS2 && wr_be[0];
    assign reload  = wr_en && addr == OFF_RELOAD && (|wr_be);
    assign init_val = init_q[CNT_W-1:0];

    always_comb begin
        ctl_view = '0;
        ctl_view[BIT_HALT]   = halt;
        ctl_view[BIT_DUMMY]  = dummy;
        ctl_view[BIT_NOREBT] = noreboot;
    end
    assign init_m = lanes(init_q, wdata, wr_be);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q   <= DATA_W'(INIT_RST);
            halt     <= 1'b1;
            noreboot <= 1'b0;
            dummy    <= 1'b0;
            flag     <= 1'b0;
            second_q <= 1'b0;
            boot_q   <= 1'b0;
        end else begin
            if (wr_init) begin
                if (init_m[CNT_W-1:0] >= MIN_VAL) init_q <= init_m;
                else init_q <= {init_m[DATA_W-1:CNT_W], init_q[CNT_W-1:0]};
            end
            if (wr_ctl) begin
                if (wr_be[1]) halt <= wdata[BIT_HALT];
                if (wr_be[0]) noreboot <= wdata[BIT_NOREBT];
                if (wr_be[1] && wdata[BIT_DUMMY]) dummy <= ~dummy;
            end
            if (set_first) flag <= 1'b1;
            else if (wr_s1 && wdata[BIT_WARN]) flag <= 1'b0;
            if (set_second) second_q <= 1'b1;
            else if (wr_s2 && wdata[BIT_SECOND]) second_q <= 1'b0;
            if (set_boot) boot_q <= 1'b1;
            else if (wr_s2 && wdata[BIT_BOOT]) boot_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_RELOAD: rdata[CNT_W-1:0] = count;
            OFF_STS1:   rdata[BIT_WARN] = flag;
            OFF_STS2: begin
                rdata[BIT_SECOND] = second_q;
                rdata[BIT_BOOT]   = boot_q;
            end
            OFF_CTL1:   rdata = ctl_view;
            OFF_INIT:   rdata = init_q;
            default:    rdata = '0;
        endcase
    end

    // R4: initial value never below the floor
    a_r4_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
        init_q[CNT_W-1:0] >= MIN_VAL);
    // R9: writing one inverts the dummy bit
    a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_be[1] && wdata[BIT_DUMMY]) |=> dummy != $past(dummy));
    // R8: expiry set wins over a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_first |=> flag);
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        wr_be,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_first,
    output logic              rst_req
);
    logic [CNT_W-1:0] count, init_val;
    logic halt, noreboot, flag, reload, run, expire;
    logic set_first, set_second, set_boot;

    wdog_regs #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN), .INIT_RST(INIT_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wr_be(wr_be), .count(count), .set_first(set_first),
        .set_second(set_second), .set_boot(set_boot), .rdata(rdata),
        .init_val(init_val), .halt(halt), .noreboot(noreboot), .flag(flag),
        .reload(reload)
    );

    wdog_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en), .reload(reload),
        .init_val(init_val), .count(count), .expire(expire)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .noreboot(noreboot), .flag(flag),
        .expire(expire), .run(run), .set_first(set_first),
        .set_second(set_second), .set_boot(set_boot), .irq(irq_first),
        .rst_req(rst_req)
    );
endmodule

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  wr_be = 2'b11;
    logic [15:0] rdata;
    logic        irq_first, rst_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    twostage_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wr_be(wr_be), .rdata(rdata), .irq_first(irq_first),
        .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cyc, WD_LIMIT);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%04h exp=0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        addr = a; wdata = d; wr_be = be; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b11;
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic tick(output logic irq_seen);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        irq_seen = irq_first;
    endtask

    task automatic ticks(input int n);
        logic s;
        for (int i = 0; i < n; i++) tick(s);
    endtask

    task automatic tick_wr(input logic [4:0] a, input logic [15:0] d, output logic irq_seen);
        addr = a; wdata = d; wr_be = 2'b11; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        irq_seen = irq_first;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        do_reset();
        rd(5'h08, v); chk("R1 ctl", v, 16'h0800);
        rd(5'h12, v); chk("R1 init", v, 16'h0004);
        rd(5'h00, v); chk("R1 count", v, 16'h0004);
        rd(5'h04, v); chk("R1 sts1", v, 16'h0000);
        rd(5'h06, v); chk("R1 sts2", v, 16'h0000);
        chk("R1 outs", {14'b0, rst_req, irq_first}, 16'h0000);
    endtask

    task automatic t_two_stage();
        logic [15:0] v; logic s;
        do_reset();
        wr(5'h12, 16'h0005);
        wr(5'h00, 16'h0001);
        rd(5'h00, v); chk("R3 reload", v, 16'h0005);
        ticks(3);
        rd(5'h00, v); chk("R2 halted hold", v, 16'h0005);
        wr(5'h08, 16'h0000);
        ticks(5);
        rd(5'h00, v); chk("R2 count zero", v, 16'h0000);
        tick(s);
        chk("R5 irq pulse", {15'b0, s}, 16'h0001);
        rd(5'h00, v); chk("R5 reload on expiry", v, 16'h0005);
        rd(5'h04, v); chk("R5 warn flag", v, 16'h0008);
        @(negedge clk);
        chk("R5 irq one cycle", {15'b0, irq_first}, 16'h0000);
        ticks(5);
        tick(s);
        chk("R6 no irq on second", {15'b0, s}, 16'h0000);
        chk("R6 rst_req", {15'b0, rst_req}, 16'h0001);
        rd(5'h06, v); chk("R6 sts2", v, 16'h0006);
        ticks(3);
        rd(5'h00, v); chk("R6 frozen", v, 16'h0005);
        wr(5'h06, 16'h0006);
        rd(5'h06, v); chk("R8 sts2 clear", v, 16'h0000);
        wr(5'h00, 16'h0001);
        wr(5'h08, 16'h0800);
        chk("R10 sticky", {15'b0, rst_req}, 16'h0001);
        do_reset();
        chk("R10 cleared by reset", {15'b0, rst_req}, 16'h0000);
    endtask

    task automatic t_noreboot();
        logic [15:0] v; logic s;
        do_reset();
        wr(5'h08, 16'h0001);
        ticks(5);
        rd(5'h04, v); chk("R7 first flag", v, 16'h0008);
        ticks(5);
        rd(5'h06, v); chk("R7 sts2 second only", v, 16'h0002);
        chk("R7 no rst_req", {15'b0, rst_req}, 16'h0000);
        rd(5'h00, v); chk("R7 reloaded", v, 16'h0004);
        tick(s);
        rd(5'h00, v); chk("R7 keeps counting", v, 16'h0003);
        ticks(4);
        chk("R7 still no rst_req", {15'b0, rst_req}, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] v; logic s;
        do_reset();
        wr(5'h08, 16'h0000);
        ticks(5);
        wr(5'h04, 16'h0000);
        rd(5'h04, v); chk("R8 write zero keeps", v, 16'h0008);
        wr(5'h04, 16'h0008);
        rd(5'h04, v); chk("R8 w1c", v, 16'h0000);
        rd(5'h00, v);
        ticks(32'(v));
        tick(s);
        chk("R8 first again irq", {15'b0, s}, 16'h0001);
        chk("R8 first again no rst", {15'b0, rst_req}, 16'h0000);
        wr(5'h04, 16'h0008);
        rd(5'h00, v);
        ticks(32'(v));
        tick_wr(5'h04, 16'h0008, s);
        rd(5'h04, v); chk("R8 set wins over clear", v, 16'h0008);
    endtask

    task automatic t_reload_race();
        logic [15:0] v; logic s;
        do_reset();
        wr(5'h08, 16'h0000);
        ticks(2);
        tick_wr(5'h00, 16'h0000, s);
        rd(5'h00, v); chk("R3 reload beats tick", v, 16'h0004);
        @(negedge clk);
        ticks(4);
        tick_wr(5'h00, 16'h0000, s);
        chk("R3 no irq at race", {15'b0, s}, 16'h0000);
        rd(5'h04, v); chk("R3 flag untouched", v, 16'h0000);
        rd(5'h00, v); chk("R3 count after race", v, 16'h0004);
        @(negedge clk);
        ticks(4);
        tick(s);
        chk("R3 later expiry", {15'b0, s}, 16'h0001);
    endtask

    task automatic t_init_lanes();
        logic [15:0] v;
        do_reset();
        wr(5'h12, 16'hFC03);
        rd(5'h12, v); chk("R4 low ignored upper kept", v, 16'hFC04);
        wr(5'h12, 16'h0007);
        rd(5'h12, v); chk("R4 valid write", v, 16'h0007);
        wr(5'h12, 16'h00FF, 2'b01);
        rd(5'h12, v); chk("R12 low lane", v, 16'h00FF);
        wr(5'h12, 16'hA400, 2'b10);
        rd(5'h12, v); chk("R12 high lane", v, 16'hA4FF);
        wr(5'h08, 16'h0001, 2'b10);
        rd(5'h08, v); chk("R12 ctl lane off", v, 16'h0000);
    endtask

    task automatic t_dummy_halt();
        logic [15:0] v;
        do_reset();
        wr(5'h08, 16'h0900);
        rd(5'h08, v); chk("R9 toggle on", v, 16'h0900);
        wr(5'h08, 16'h0800);
        rd(5'h08, v); chk("R9 zero keeps", v, 16'h0900);
        wr(5'h08, 16'h0100);
        rd(5'h08, v); chk("R9 toggle off run", v, 16'h0000);
        ticks(2);
        rd(5'h00, v); chk("R9 counting unaffected", v, 16'h0002);
        wr(5'h08, 16'h0800);
        ticks(3);
        rd(5'h00, v); chk("R11 halt holds", v, 16'h0002);
        wr(5'h08, 16'h0000);
        ticks(3);
        rd(5'h04, v); chk("R11 first expiry", v, 16'h0008);
        wr(5'h08, 16'h0800);
        ticks(2);
        rd(5'h04, v); chk("R11 halt keeps flag", v, 16'h0008);
    endtask

    initial begin
        t_reset_state();
        t_two_stage();
        t_noreboot();
        t_w1c();
        t_reload_race();
        t_init_lanes();
        t_dummy_halt();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule